// File: doc/BRIEF.md
# Linked-Descriptor Stream Capture Engine

This engine is the receive half of a descriptor-driven DMA channel. Software builds a chain of four-word descriptors in memory, each naming a link to the following descriptor, a buffer start, a flag word and a buffer end. It then pulses a start strobe with the address of the first descriptor and the address of a context word. The engine fetches the descriptor and takes beats from a byte-counted stream. It writes each beat into the current buffer as a 32-bit word with byte enables, and reports how many bytes of each beat it kept.

A buffer is closed either when it is full or when a beat carries the end-of-packet mark. On close, the engine writes the real fill pointer over the descriptor's end word and writes back the flag word, setting the received-EOP flag when the packet ended. It raises raw interrupt bits and pulses an update request only when those bits gained a new one. It then follows the link, or, if the descriptor is the last in the list, marks the context word disabled and parks in an end-of-list state. In that state every beat is consumed and reported as zero bytes kept.

Beats must start at word-aligned pointers: only the final beat of a packet may carry fewer than four bytes. Buffer starts are word aligned, and buffer ends may fall on any byte.

Top module: `stream_dma_in`

## Requirements
- R1: After reset, s_ready_o, s_ack_valid_o, mem_req_o, irq_set_o and eol_o are low and irq_raw_o is 0.
- R2: The number of bytes kept from a beat is the smaller of s_nbytes_i and (buffer end minus current pointer). It is reported on s_ack_bytes_o with s_ack_valid_o high for one cycle, in the cycle after the beat is taken.
- R3: Kept bytes are written at the current pointer (word aligned). mem_be_o has one bit set per kept byte, starting from bit 0, and other bytes of that word stay unchanged.
- R4: A descriptor is closed when the pointer reaches its end. The word at descriptor+12 is rewritten with the fill pointer, and the flag word at descriptor+8 is rewritten.
- R5: When a beat carries s_eop_i, the descriptor is closed even if space remains. Its end word is rewritten with the actual fill pointer, and bit 11 of its flag word is set.
- R6: On close of a descriptor whose flag bit 4 is set, raw interrupt bits 0 and 1 are set.
- R7: On close caused by end-of-packet, raw interrupt bit 3 is set.
- R8: irq_set_o pulses for one cycle on a close only if the close sets a raw bit that was not already set.
- R9: Closing a descriptor with flag bit 0 set writes the context word with bit 15 set, and then raises eol_o.
- R10: While eol_o is high, offered beats are consumed with zero bytes reported, and no memory write is made.
- R11: Closing a descriptor without flag bit 0 fetches the descriptor at its link word (offset 0) and continues filling from that descriptor's buffer start.
- R12: s_ready_o is low while idle and while a descriptor fetch, payload write or write-back is in progress.
- R13: Each set bit of irq_clr_i clears the matching raw interrupt bit, and a start pulse from end-of-list restarts the channel with a new descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, honoured when idle or at end-of-list |
| desc_addr_i | input | ADDR_W | First descriptor address |
| ctx_addr_i | input | ADDR_W | Context word address |
| s_valid_i | input | 1 | Stream beat valid |
| s_data_i | input | DATA_W | Stream beat data, byte 0 in bits 7:0 |
| s_nbytes_i | input | CW | Bytes in the beat (1 to DATA_W/8) |
| s_eop_i | input | 1 | Beat ends the packet |
| s_ready_o | output | 1 | Engine takes a beat this cycle |
| s_ack_valid_o | output | 1 | Kept-byte count valid |
| s_ack_bytes_o | output | CW | Bytes kept from the last beat |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Word-aligned byte address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_be_o | output | DATA_W/8 | Write byte enables |
| mem_rdata_i | input | DATA_W | Read data, valid with the acknowledge |
| mem_ack_i | input | 1 | Request completed |
| irq_clr_i | input | 4 | Raw interrupt bit clears |
| irq_raw_o | output | 4 | Raw interrupt bits |
| irq_set_o | output | 1 | Interrupt update request pulse |
| eol_o | output | 1 | Channel at end of list |

## Verification
A three-descriptor chain is fed a table of beats. Full beats check ordinary filling. A beat larger than the remaining space shows truncation against the end pointer. Beats marked end-of-packet, both full and partial, show early close and the rewrite of the end word. A descriptor that closes while its interrupt bits are already set shows that no update is requested. A beat offered after end-of-list shows that nothing is kept. Directed tests then clear the raw bits and restart from end-of-list, to show that a fresh update request appears.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
  // Flag-word bit positions decoded by software
  localparam int FLG_LAST  = 0;
  localparam int FLG_IRQ   = 4;
  localparam int FLG_GOTEP = 11;
  localparam int CTX_OFF   = 15;
  // Descriptor word byte offsets
  localparam int OFS_LINK  = 0;
  localparam int OFS_BUF   = 4;
  localparam int OFS_FLAGS = 8;
  localparam int OFS_END   = 12;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_RUN, S_WDATA, S_WB_END, S_WB_FLG, S_WB_CTX, S_EOL
  } sdi_state_e;
endpackage

// File: rtl/sdi_space_limit.sv
module sdi_space_limit #(
  parameter int ADDR_W = 32,
  parameter int NB     = 4,
  localparam int CW    = $clog2(NB + 1)
) (
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [ADDR_W-1:0] end_i,
  input  logic [CW-1:0]     nbytes_i,
  output logic [CW-1:0]     keep_o,
  output logic [NB-1:0]     be_o
);
  logic [ADDR_W-1:0] room;
  assign room   = end_i - ptr_i;
  assign keep_o = (ADDR_W'(nbytes_i) > room) ? CW'(room) : nbytes_i;

  for (genvar i = 0; i < NB; i++) begin : g_be
    assign be_o[i] = (CW'(i) < keep_o);
  end
endmodule

// File: rtl/sdi_close_logic.sv
module sdi_close_logic
  import sdi_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] flags_i,
  input  logic              eop_i,
  input  logic [3:0]        raw_i,
  output logic [DATA_W-1:0] flags_o,
  output logic [3:0]        set_o,
  output logic              raise_o
);
  always_comb begin
    flags_o = flags_i;
    set_o   = 4'b0000;
    if (flags_i[FLG_IRQ]) set_o = set_o | 4'b0011;
    if (eop_i) begin
      flags_o[FLG_GOTEP] = 1'b1;
      set_o = set_o | 4'b1000;
    end
  end
  assign raise_o = |(set_o & ~raw_i);
endmodule

// File: rtl/stream_dma_in.sv
module stream_dma_in
  import sdi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int CW    = $clog2(NB + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] desc_addr_i,
  input  logic [ADDR_W-1:0] ctx_addr_i,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic [CW-1:0]     s_nbytes_i,
  input  logic              s_eop_i,
  output logic              s_ready_o,
  output logic              s_ack_valid_o,
  output logic [CW-1:0]     s_ack_bytes_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [NB-1:0]     mem_be_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  input  logic [3:0]        irq_clr_i,
  output logic [3:0]        irq_raw_o,
  output logic              irq_set_o,
  output logic              eol_o
);
  localparam int AL = $clog2(NB);

  sdi_state_e        state;
  logic [1:0]        widx;
  logic [ADDR_W-1:0] d_addr, c_addr, d_link, d_buf, d_end, ptr;
  logic [DATA_W-1:0] d_flags, b_data;
  logic [NB-1:0]     b_be;
  logic [CW-1:0]     b_keep;
  logic              b_eop;

  logic [CW-1:0]     keep;
  logic [NB-1:0]     be;
  logic [DATA_W-1:0] flags_cl;
  logic [3:0]        set_cl;
  logic              raise_cl;
  logic [ADDR_W-1:0] fill;
  logic              closing;

  sdi_space_limit #(.ADDR_W(ADDR_W), .NB(NB)) u_limit (
    .ptr_i(ptr), .end_i(d_end), .nbytes_i(s_nbytes_i),
    .keep_o(keep), .be_o(be)
  );

  sdi_close_logic #(.DATA_W(DATA_W)) u_close (
    .flags_i(d_flags), .eop_i(b_eop), .raw_i(irq_raw_o),
    .flags_o(flags_cl), .set_o(set_cl), .raise_o(raise_cl)
  );

  assign fill    = ptr + ADDR_W'(b_keep);
  assign closing = (fill == d_end) || b_eop;

  assign s_ready_o = (state == S_RUN) || (state == S_EOL);
  assign eol_o     = (state == S_EOL);
  assign mem_req_o = (state == S_FETCH) || (state == S_WDATA) || (state == S_WB_END)
                  || (state == S_WB_FLG) || (state == S_WB_CTX);
  assign mem_we_o  = (state != S_FETCH);

  always_comb begin
    mem_addr_o  = d_addr + ADDR_W'({widx, 2'b00});
    mem_wdata_o = b_data;
    mem_be_o    = {NB{1'b1}};
    case (state)
      S_WDATA: begin
        mem_addr_o = {ptr[ADDR_W-1:AL], {AL{1'b0}}};
        mem_be_o   = b_be;
      end
      S_WB_END: begin
        mem_addr_o  = d_addr + ADDR_W'(OFS_END);
        mem_wdata_o = DATA_W'(d_end);
      end
      S_WB_FLG: begin
        mem_addr_o  = d_addr + ADDR_W'(OFS_FLAGS);
        mem_wdata_o = d_flags;
      end
      S_WB_CTX: begin
        mem_addr_o  = c_addr;
        mem_wdata_o = DATA_W'(1) << CTX_OFF;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      widx          <= '0;
      d_addr        <= '0;
      c_addr        <= '0;
      d_link        <= '0;
      d_buf         <= '0;
      d_end         <= '0;
      d_flags       <= '0;
      ptr           <= '0;
      b_data        <= '0;
      b_be          <= '0;
      b_keep        <= '0;
      b_eop         <= 1'b0;
      s_ack_valid_o <= 1'b0;
      s_ack_bytes_o <= '0;
      irq_raw_o     <= 4'b0000;
      irq_set_o     <= 1'b0;
    end else begin
      s_ack_valid_o <= 1'b0;
      irq_set_o     <= 1'b0;
      irq_raw_o     <= irq_raw_o & ~irq_clr_i;
      case (state)
        S_IDLE, S_EOL: begin
          if (state == S_EOL && s_valid_i) begin
            s_ack_valid_o <= 1'b1;
            s_ack_bytes_o <= '0;
          end
          if (start_i) begin
            d_addr <= desc_addr_i;
            c_addr <= ctx_addr_i;
            widx   <= '0;
            state  <= S_FETCH;
          end
        end
        S_FETCH: if (mem_ack_i) begin
          widx <= widx + 2'd1;
          case (widx)
            2'd0: d_link  <= ADDR_W'(mem_rdata_i);
            2'd1: d_buf   <= ADDR_W'(mem_rdata_i);
            2'd2: d_flags <= mem_rdata_i;
            default: begin
              d_end <= ADDR_W'(mem_rdata_i);
              ptr   <= d_buf;
              state <= S_RUN;
            end
          endcase
        end
        S_RUN: if (s_valid_i) begin
          b_data        <= s_data_i;
          b_be          <= be;
          b_keep        <= keep;
          b_eop         <= s_eop_i;
          s_ack_valid_o <= 1'b1;
          s_ack_bytes_o <= keep;
          state         <= S_WDATA;
        end
        S_WDATA: if (mem_ack_i) begin
          ptr <= fill;
          if (closing) begin
            d_end     <= fill;
            d_flags   <= flags_cl;
            irq_raw_o <= (irq_raw_o & ~irq_clr_i) | set_cl;
            irq_set_o <= raise_cl;
            state     <= S_WB_END;
          end else begin
            state <= S_RUN;
          end
        end
        S_WB_END: if (mem_ack_i) state <= S_WB_FLG;
        S_WB_FLG: if (mem_ack_i) begin
          if (d_flags[FLG_LAST]) begin
            state <= S_WB_CTX;
          end else begin
            d_addr <= d_link + ADDR_W'(OFS_LINK);
            widx   <= '0;
            state  <= S_FETCH;
          end
        end
        S_WB_CTX: if (mem_ack_i) state <= S_EOL;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R12
  ready_mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
    s_ready_o |-> !mem_req_o);
  // R2
  ack_range_chk: assert property (@(posedge clk) disable iff (rst)
    s_ack_valid_o |-> (s_ack_bytes_o <= CW'(NB)));
  // R10
  eol_keep_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (eol_o && s_valid_i && !start_i) |=> (s_ack_valid_o && s_ack_bytes_o == '0));
  // R9
  eol_after_ctx_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(eol_o) |-> $past(mem_req_o && mem_we_o && mem_ack_i));
  // R8
  raise_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    irq_set_o |-> (irq_raw_o != 4'b0000));
endmodule

// File: tb/test_stream_dma_in.sv
module test_stream_dma_in;
  localparam int AW = 32, DW = 32, NB = 4, CW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, start, s_valid, s_eop;
  logic [AW-1:0] desc_addr, ctx_addr;
  logic [DW-1:0] s_data;
  logic [CW-1:0] s_nbytes;
  logic s_ready, ack_v, mem_req, mem_we, irq_set, eol;
  logic [CW-1:0] ack_b;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [NB-1:0] mem_be;
  logic mem_ack;
  logic [3:0] irq_clr, irq_raw;

  stream_dma_in #(.ADDR_W(AW), .DATA_W(DW)) i_stream_dma_in (
    .clk(clk), .rst(rst), .start_i(start), .desc_addr_i(desc_addr), .ctx_addr_i(ctx_addr),
    .s_valid_i(s_valid), .s_data_i(s_data), .s_nbytes_i(s_nbytes), .s_eop_i(s_eop),
    .s_ready_o(s_ready), .s_ack_valid_o(ack_v), .s_ack_bytes_o(ack_b),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_be_o(mem_be), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .irq_clr_i(irq_clr), .irq_raw_o(irq_raw), .irq_set_o(irq_set), .eol_o(eol)
  );

  logic [31:0] mem [0:511];
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        for (int b = 0; b < NB; b++)
          if (mem_be[b]) mem[mem_addr[10:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[10:2]];
      end
    end
  end

  int irq_cnt = 0;
  int wr_cnt = 0;
  always @(posedge clk) begin
    if (!rst && irq_set) irq_cnt <= irq_cnt + 1;
    if (!rst && mem_req && mem_we && mem_ack) wr_cnt <= wr_cnt + 1;
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input int addr);
    return mem[addr[10:2]];
  endfunction

  // Beat table: bytes, eop, data, expected kept, expected cumulative update pulses
  localparam int NV = 7;
  localparam logic [2:0]  V_NB   [NV] = '{3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd3, 3'd4};
  localparam logic        V_EOP  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [31:0] V_DATA [NV] = '{32'h11223344, 32'h01020304, 32'h55667788,
                                          32'h99AABBCC, 32'hDEADBEEF, 32'h00CCDDEE, 32'h77777777};
  localparam logic [2:0]  V_KEEP [NV] = '{3'd4, 3'd4, 3'd2, 3'd4, 3'd4, 3'd3, 3'd0};
  localparam int          V_IRQ  [NV] = '{0, 0, 1, 2, 2, 2, 2};

  task automatic send(input logic [2:0] nb, input logic ep, input logic [31:0] d,
                      output logic got_v, output logic [2:0] got_b);
    @(negedge clk);
    s_valid = 1'b1; s_nbytes = nb; s_eop = ep; s_data = d;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    got_v = ack_v; got_b = ack_b;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    logic gv;
    logic [2:0] gb;
    int wr_before;
    for (int i = 0; i < 512; i++) mem[i] = 32'hAAAAAAAA;
    // descriptor A: intr flag, 10-byte buffer
    mem[32'h100 >> 2] = 32'h140; mem[32'h104 >> 2] = 32'h400;
    mem[32'h108 >> 2] = 32'h10;  mem[32'h10C >> 2] = 32'h40A;
    // descriptor B: no flags, 16-byte buffer
    mem[32'h140 >> 2] = 32'h180; mem[32'h144 >> 2] = 32'h500;
    mem[32'h148 >> 2] = 32'h0;   mem[32'h14C >> 2] = 32'h510;
    // descriptor C: last + intr, 8-byte buffer
    mem[32'h180 >> 2] = 32'h0;   mem[32'h184 >> 2] = 32'h600;
    mem[32'h188 >> 2] = 32'h11;  mem[32'h18C >> 2] = 32'h608;
    mem[32'h1C0 >> 2] = 32'h0;
    rst = 1'b1; start = 1'b0; s_valid = 1'b0; s_eop = 1'b0; s_nbytes = '0; s_data = '0;
    desc_addr = '0; ctx_addr = '0; irq_clr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!s_ready && !ack_v && !mem_req && !irq_set && !eol && irq_raw == 0, "R1",
        {s_ready, ack_v, mem_req, irq_set, eol, irq_raw}, 0);

    desc_addr = 32'h100; ctx_addr = 32'h1C0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R12: fetch in progress
    chk(!s_ready && mem_req, "R12", {s_ready, mem_req}, 2'b01);

    for (int v = 0; v < NV; v++) begin
      send(V_NB[v], V_EOP[v], V_DATA[v], gv, gb);
      // R2 / R10
      chk(gv && gb == V_KEEP[v], v == 6 ? "R10" : "R2", {gv, gb}, {1'b1, V_KEEP[v]});
      wr_before = wr_cnt;
      repeat (30) @(negedge clk);
      // R8
      chk(irq_cnt == V_IRQ[v], "R8", irq_cnt, V_IRQ[v]);
      if (v == 6) chk(wr_cnt == wr_before, "R10", wr_cnt, wr_before);
    end

    // R3
    chk(rd(32'h400) == 32'h11223344, "R3", rd(32'h400), 32'h11223344);
    chk(rd(32'h408) == 32'hAAAA7788, "R3", rd(32'h408), 32'hAAAA7788);
    // R4
    chk(rd(32'h10C) == 32'h40A && rd(32'h108) == 32'h10, "R4", rd(32'h10C), 32'h40A);
    // R5
    chk(rd(32'h14C) == 32'h504, "R5", rd(32'h14C), 32'h504);
    chk(rd(32'h148) == 32'h800, "R5", rd(32'h148), 32'h800);
    chk(rd(32'h18C) == 32'h607 && rd(32'h188) == 32'h811, "R5", rd(32'h188), 32'h811);
    // R11
    chk(rd(32'h500) == 32'h99AABBCC && rd(32'h600) == 32'hDEADBEEF, "R11", rd(32'h600), 32'hDEADBEEF);
    chk(rd(32'h604) == 32'hAACCDDEE, "R3", rd(32'h604), 32'hAACCDDEE);
    // R6 / R7
    chk(irq_raw == 4'hB, "R6", irq_raw, 4'hB);
    // R9
    chk(rd(32'h1C0) == 32'h8000 && eol, "R9", rd(32'h1C0), 32'h8000);
    // R10
    chk(rd(32'h608) == 32'hAAAAAAAA, "R10", rd(32'h608), 32'hAAAAAAAA);

    // R13: clear raw bits
    @(negedge clk); irq_clr = 4'hB;
    @(negedge clk); irq_clr = 4'h0;
    chk(irq_raw == 4'h0, "R13", irq_raw, 0);

    // R13: restart from end-of-list on descriptor C (end word now 0x607)
    desc_addr = 32'h180; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!eol && !s_ready, "R13", {eol, s_ready}, 2'b00);
    send(3'd4, 1'b1, 32'h12345678, gv, gb);
    chk(gv && gb == 3'd4, "R2", gb, 4);
    repeat (30) @(negedge clk);
    chk(irq_cnt == 3, "R8", irq_cnt, 3);
    chk(irq_raw == 4'hB, "R7", irq_raw, 4'hB);
    chk(rd(32'h18C) == 32'h604 && eol, "R5", rd(32'h18C), 32'h604);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule